// File: doc/BRIEF.md
# 32-Pin Register-Mapped GPIO Port

This block is a general-purpose I/O port of 32 pins sitting behind a simple single-cycle 32-bit register bus. Software controls the pins through port-wide registers: an output latch, a direction latch, a read-only input register and a sticky short-circuit status word. It also uses one small configuration register per pin. The output and direction latches each have write-one-to-set and write-one-to-clear aliases, so a single pin can be changed without a read-modify-write.

Each pin works out the level it reads back from four things: the external drive, its own output driver, its input-buffer connect bit and its pull resistor setting. A pin set as an output with its input buffer connected reads back its own output value. A disconnected input buffer ignores the outside world and reports the pull level. An undriven, connected pin with no pull keeps the last level it saw. The external side of each pin is modelled as a drive-enable and drive-value pair. The pad side is an output-enable bus and an output-value bus. When an output pin meets an external driver of the opposite level, a per-pin sticky conflict bit is set. The OR of all conflict bits is a single flag.

The block has no state machine. Its behaviour is held entirely in the latches, the per-pin configuration and the registered input levels.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Word addresses are 0 output latch, 1 output set, 2 output clear, 3 input, 4 direction, 5 direction set, 6 direction clear, 7 conflict status, and 32+n the configuration of pin n. After reset all port words read 0, every pin configuration reads 0x2, and pad_oe and conflict_any are 0.
- R2: A write to word 4 loads the direction latch. A write to word 5 sets, and a write to word 6 clears, each direction bit written as 1. Reads of words 5 and 6 return the direction latch. pad_oe equals the direction latch, and it changes only after a write.
- R3: Configuration bit 0 of pin n is the same storage as direction bit n. A configuration write changes direction bit n, and a direction change shows up in configuration bit 0.
- R4: Words 0, 1 and 2 load, set and clear output latch bits, one bit per written 1. Reads of words 1 and 2 return the output latch. pad_out carries the output latch.
- R5: Configuration bit 1 = 1 disconnects the input buffer. Configuration bits 3:2 are the pull: 00 none, 01 down, 11 up (10 acts as none). For a connected input pin, the input bit follows ext_val while ext_en is 1.
- R6: For a connected, undriven input pin, the input bit reads 1 with pull-up, 0 with pull-down, and keeps its last value with no pull.
- R7: For a disconnected pin, the external drive is ignored and the input bit reads 1 with pull-up and 0 otherwise.
- R8: For a connected output pin, the input bit reads the pin's output latch bit, whatever the external drive.
- R9: An output pin whose ext_en is 1 and whose ext_val differs from its output bit sets status bit n at the next edge. The bit stays set until software writes 1 to it at word 7; a new conflict in the same cycle wins over the clear. conflict_any is the OR of the status bits.
- R10: Writes to word 3 change nothing. Reads of unmapped words 8 to 31 return 0.
- R11: bus_rdata is loaded at the clock edge where bus_rd is 1. The input register captures a pin's resolved level at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_en | input | 32 | External driver enable per pin |
| ext_val | input | 32 | External driver level per pin |
| pad_oe | output | 32 | Output enable per pin |
| pad_out | output | 32 | Output level per pin |
| conflict_any | output | 1 | OR of the sticky conflict bits |

## Verification
Latch writes take effect at the edge that samples bus_wr, so pad_oe and pad_out are due one edge after a write. A conflict condition shows on conflict_any one edge after it appears. A pin level is due in the input register one edge after any change to the configuration or the external drive, and read data is due one edge after the read strobe. The bench drives everything at the falling edge and reads back only after a full idle cycle. It checks the one-edge delay directly on pad_oe and conflict_any by sampling just before and just after the edge that should change them.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Port-wide register selector, the low three bits of a port word address
    typedef enum logic [2:0] {
        REG_OUT    = 3'd0,
        REG_OUTSET = 3'd1,
        REG_OUTCLR = 3'd2,
        REG_IN     = 3'd3,
        REG_DIR    = 3'd4,
        REG_DIRSET = 3'd5,
        REG_DIRCLR = 3'd6,
        REG_CONFL  = 3'd7
    } port_reg_e;

    // Pull field codes of the per-pin configuration
    localparam logic [1:0] PULL_NONE = 2'b00;
    localparam logic [1:0] PULL_DOWN = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b11;

    // Configuration reset value: input, buffer disconnected, no pull
    localparam logic [3:0] CFG_RESET = 4'b0010;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DW     = 32,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic [NPINS-1:0]        conf_det,
    output logic [NPINS-1:0]        out_q,
    output logic [NPINS-1:0]        dir_q,
    output logic [NPINS-1:0]        disc_q,
    output logic [NPINS-1:0][1:0]   pull_q,
    output logic [NPINS-1:0]        conf_q
);

    localparam int CFG_BASE = 2 ** (ADDR_W - 1);

    logic                port_hit;
    port_reg_e           sel;
    logic [NPINS-1:0]    cfg_we;
    logic [NPINS-1:0]    wbits;
    logic [NPINS-1:0]    out_d;
    logic [NPINS-1:0]    dir_d;
    logic [NPINS-1:0]    conf_clr;

    assign port_hit = bus_wr && (bus_addr[ADDR_W-1:3] == '0);
    assign sel      = port_reg_e'(bus_addr[2:0]);
    assign wbits    = bus_wdata[NPINS-1:0];

    // One configuration word per pin
    for (genvar i = 0; i < NPINS; i++) begin : g_cfg_dec
        assign cfg_we[i] = bus_wr && (bus_addr == ADDR_W'(CFG_BASE + i));
    end

    always_comb begin
        out_d    = out_q;
        dir_d    = dir_q;
        conf_clr = '0;
        if (port_hit) begin
            unique case (sel)
                REG_OUT:    out_d    = wbits;
                REG_OUTSET: out_d    = out_q | wbits;
                REG_OUTCLR: out_d    = out_q & ~wbits;
                REG_IN:     out_d    = out_q;
                REG_DIR:    dir_d    = wbits;
                REG_DIRSET: dir_d    = dir_q | wbits;
                REG_DIRCLR: dir_d    = dir_q & ~wbits;
                REG_CONFL:  conf_clr = wbits;
            endcase
        end
        // Configuration bit 0 is the same storage as the direction bit
        dir_d = (dir_d & ~cfg_we) | (cfg_we & {NPINS{bus_wdata[0]}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            conf_q <= '0;
        end else begin
            out_q  <= out_d;
            dir_q  <= dir_d;
            // A new conflict wins over a clear in the same cycle
            conf_q <= (conf_q & ~conf_clr) | conf_det;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPINS; i++) begin
                disc_q[i] <= CFG_RESET[1];
                pull_q[i] <= CFG_RESET[3:2];
            end
        end else begin
            for (int i = 0; i < NPINS; i++) begin
                if (cfg_we[i]) begin
                    disc_q[i] <= bus_wdata[1];
                    pull_q[i] <= bus_wdata[3:2];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        dir_q,
    input  logic [NPINS-1:0]        out_q,
    input  logic [NPINS-1:0]        disc_q,
    input  logic [NPINS-1:0][1:0]   pull_q,
    input  logic [NPINS-1:0]        ext_en,
    input  logic [NPINS-1:0]        ext_val,
    output logic [NPINS-1:0]        in_q,
    output logic [NPINS-1:0]        conf_det
);

    logic [NPINS-1:0] in_d;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic up;
        logic dn;
        assign up = (pull_q[i] == PULL_UP);
        assign dn = (pull_q[i] == PULL_DOWN);

        // Priority: disconnected buffer, own driver, external driver, pull, keeper
        assign in_d[i] = disc_q[i] ? up        :
                         dir_q[i]  ? out_q[i]  :
                         ext_en[i] ? ext_val[i] :
                         up        ? 1'b1      :
                         dn        ? 1'b0      :
                                     in_q[i];

        assign conf_det[i] = dir_q[i] & ext_en[i] & (ext_val[i] ^ out_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DW     = 32,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_rd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NPINS-1:0]        out_q,
    input  logic [NPINS-1:0]        dir_q,
    input  logic [NPINS-1:0]        in_q,
    input  logic [NPINS-1:0]        conf_q,
    input  logic [NPINS-1:0]        disc_q,
    input  logic [NPINS-1:0][1:0]   pull_q,
    output logic [DW-1:0]           bus_rdata
);

    localparam int SLOTS = 2 ** (ADDR_W - 1);

    logic [SLOTS-1:0][3:0] slot;
    logic [DW-1:0]         rd_d;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NPINS) begin : g_live
            assign slot[i] = {pull_q[i], disc_q[i], dir_q[i]};
        end else begin : g_empty
            assign slot[i] = '0;
        end
    end

    always_comb begin
        rd_d = '0;
        if (bus_addr[ADDR_W-1]) begin
            rd_d = DW'(slot[bus_addr[ADDR_W-2:0]]);
        end else if (bus_addr[ADDR_W-2:3] == '0) begin
            unique case (port_reg_e'(bus_addr[2:0]))
                REG_OUT, REG_OUTSET, REG_OUTCLR: rd_d = DW'(out_q);
                REG_IN:                          rd_d = DW'(in_q);
                REG_DIR, REG_DIRSET, REG_DIRCLR: rd_d = DW'(dir_q);
                REG_CONFL:                       rd_d = DW'(conf_q);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_d;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DW     = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  ext_en,
    input  logic [NPINS-1:0]  ext_val,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic              conflict_any
);

    logic [NPINS-1:0]      out_q;
    logic [NPINS-1:0]      dir_q;
    logic [NPINS-1:0]      disc_q;
    logic [NPINS-1:0][1:0] pull_q;
    logic [NPINS-1:0]      conf_q;
    logic [NPINS-1:0]      conf_det;
    logic [NPINS-1:0]      in_q;

    gpio_port_regs #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .conf_det (conf_det),
        .out_q    (out_q),
        .dir_q    (dir_q),
        .disc_q   (disc_q),
        .pull_q   (pull_q),
        .conf_q   (conf_q)
    );

    gpio_pin_resolve #(.NPINS(NPINS)) i_resolve (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .disc_q  (disc_q),
        .pull_q  (pull_q),
        .ext_en  (ext_en),
        .ext_val (ext_val),
        .in_q    (in_q),
        .conf_det(conf_det)
    );

    gpio_read_mux #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) i_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .out_q    (out_q),
        .dir_q    (dir_q),
        .in_q     (in_q),
        .conf_q   (conf_q),
        .disc_q   (disc_q),
        .pull_q   (pull_q),
        .bus_rdata(bus_rdata)
    );

    assign pad_oe       = dir_q;
    assign pad_out      = out_q;
    assign conflict_any = |conf_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DW     = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [NPINS-1:0]  ext_en,
    input logic [NPINS-1:0]  ext_val,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_out,
    input logic              conflict_any
);

    localparam logic [ADDR_W-1:0] A_OUTSET = ADDR_W'(REG_OUTSET);
    localparam logic [ADDR_W-1:0] A_OUTCLR = ADDR_W'(REG_OUTCLR);
    localparam logic [ADDR_W-1:0] A_DIRSET = ADDR_W'(REG_DIRSET);
    localparam logic [ADDR_W-1:0] A_DIRCLR = ADDR_W'(REG_DIRCLR);
    localparam logic [ADDR_W-1:0] A_CONFL  = ADDR_W'(REG_CONFL);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pad_oe == '0) && !conflict_any);

    p_dirset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIRSET) |=>
            ((pad_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    p_dirclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIRCLR) |=>
            ((pad_oe & $past(bus_wdata[NPINS-1:0])) == '0));

    p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pad_oe));

    p_cfg_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1]) |=>
            (pad_oe[$past(bus_addr[ADDR_W-2:0])] == $past(bus_wdata[0])));

    p_outset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OUTSET) |=>
            ((pad_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    p_outclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OUTCLR) |=>
            ((pad_out & $past(bus_wdata[NPINS-1:0])) == '0));

    p_conflict_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ext_en & (ext_val ^ pad_out)) != '0) |=> conflict_any);

    p_conflict_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict_any && !(bus_wr && bus_addr == A_CONFL)) |=> conflict_any);

endmodule

bind gpio_port_ctrl gpio_port_chk #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ext_en      (ext_en),
    .ext_val     (ext_val),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .conflict_any(conflict_any)
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

    localparam int NPINS  = 32;
    localparam int DW     = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] W_OUT = 6'd0, W_OUTSET = 6'd1, W_OUTCLR = 6'd2,
                                  W_IN = 6'd3, W_DIR = 6'd4, W_DIRSET = 6'd5,
                                  W_DIRCLR = 6'd6, W_CONFL = 6'd7, W_CFG = 6'd32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NPINS-1:0]  ext_en = '0;
    logic [NPINS-1:0]  ext_val = '0;
    logic [NPINS-1:0]  pad_oe;
    logic [NPINS-1:0]  pad_out;
    logic              conflict_any;

    int  n_vec = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ctrl #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_en(ext_en), .ext_val(ext_val), .pad_oe(pad_oe),
        .pad_out(pad_out), .conflict_any(conflict_any)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive(input int pin, input logic en, input logic val);
        @(negedge clk);
        ext_en[pin] = en; ext_val[pin] = val;
    endtask

    function automatic logic [31:0] bitof(input logic [31:0] w, input int n);
        return {31'd0, w[n]};
    endfunction

    task automatic t_reset_r1();
        logic [31:0] r;
        for (int a = 0; a < 8; a++) begin
            rd(ADDR_W'(a), r);
            check($sformatf("R1 port word %0d after reset", a), r, 32'h0);
        end
        for (int p = 0; p < NPINS; p++) begin
            rd(W_CFG + ADDR_W'(p), r);
            check($sformatf("R1 cfg pin %0d after reset", p), r, 32'h2);
        end
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 conflict_any after reset", {31'd0, conflict_any}, 32'h0);
    endtask

    task automatic t_dir_r2_r3();
        logic [31:0] r;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = W_DIRSET; bus_wdata = 32'h8000_0001;
        check("R11 pad_oe before the write edge", pad_oe, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R2 pad_oe one edge after dirset", pad_oe, 32'h8000_0001);
        rd(W_DIR, r);      check("R2 dir after dirset", r, 32'h8000_0001);
        rd(W_DIRSET, r);   check("R2 dirset alias reads dir", r, 32'h8000_0001);
        rd(W_DIRCLR, r);   check("R2 dirclr alias reads dir", r, 32'h8000_0001);
        rd(W_CFG, r);      check("R3 cfg pin0 mirrors dir set", r, 32'h3);
        rd(W_CFG + 31, r); check("R3 cfg pin31 mirrors dir set", r, 32'h3);
        wr(W_DIRCLR, 32'h8000_0001);
        rd(W_DIR, r);      check("R2 dir after dirclr", r, 32'h0);
        rd(W_CFG + 31, r); check("R3 cfg pin31 mirrors dir clear", r, 32'h2);
        wr(W_DIR, 32'h8000_0001);
        rd(W_CFG, r);      check("R3 cfg pin0 after direct dir write", r, 32'h3);
        wr(W_DIR, 32'h0);
        wr(W_CFG + 3, 32'h3);
        rd(W_DIR, r);      check("R3 cfg write sets dir bit 3", r, 32'h8);
        check("R3 pad_oe after cfg write", pad_oe, 32'h8);
        wr(W_CFG + 3, 32'h2);
        rd(W_DIR, r);      check("R3 cfg write clears dir bit 3", r, 32'h0);
    endtask

    task automatic t_out_r4();
        logic [31:0] r;
        wr(W_OUT, 32'h0000_00F0);
        check("R4 pad_out after direct write", pad_out, 32'h0000_00F0);
        wr(W_OUTSET, 32'h0000_0101);
        rd(W_OUT, r);    check("R4 outset sets only written bits", r, 32'h0000_01F1);
        wr(W_OUTCLR, 32'h0000_0030);
        rd(W_OUTCLR, r); check("R4 outclr alias reads out", r, 32'h0000_01C1);
        rd(W_OUTSET, r); check("R4 outset alias reads out", r, 32'h0000_01C1);
        check("R4 pad_out after clear", pad_out, 32'h0000_01C1);
        wr(W_OUT, 32'h0);
    endtask

    task automatic t_input_r5_r6();
        logic [31:0] r;
        wr(W_CFG + 5, 32'h0);
        drive(5, 1'b1, 1'b1);
        rd(W_IN, r); check("R5 connected input follows ext high", bitof(r, 5), 32'h1);
        drive(5, 1'b1, 1'b0);
        rd(W_IN, r); check("R5 connected input follows ext low", r, 32'h0);
        drive(5, 1'b1, 1'b1);
        drive(5, 1'b0, 1'b1);
        rd(W_IN, r); check("R6 undriven no-pull keeps last level", bitof(r, 5), 32'h1);
        drive(5, 1'b0, 1'b0);
        rd(W_IN, r); check("R6 undriven level ignores ext_val", bitof(r, 5), 32'h1);
        wr(W_CFG + 5, 32'h4);
        rd(W_IN, r); check("R6 undriven pull-down reads 0", bitof(r, 5), 32'h0);
        wr(W_CFG + 5, 32'hC);
        rd(W_IN, r); check("R6 undriven pull-up reads 1", bitof(r, 5), 32'h1);
        wr(W_CFG + 5, 32'h2);
    endtask

    task automatic t_disc_r7();
        logic [31:0] r;
        drive(9, 1'b1, 1'b0);
        wr(W_CFG + 9, 32'hE);
        rd(W_IN, r); check("R7 disconnected pull-up ignores ext low", bitof(r, 9), 32'h1);
        drive(9, 1'b1, 1'b1);
        wr(W_CFG + 9, 32'h6);
        rd(W_IN, r); check("R7 disconnected pull-down ignores ext high", bitof(r, 9), 32'h0);
        wr(W_CFG + 9, 32'h2);
        rd(W_IN, r); check("R7 disconnected no pull reads 0", bitof(r, 9), 32'h0);
        drive(9, 1'b0, 1'b0);
    endtask

    task automatic t_loop_r8();
        logic [31:0] r;
        wr(W_CFG + 7, 32'h1);
        wr(W_OUTSET, 32'h80);
        check("R8 pad_oe for output pin", pad_oe, 32'h80);
        rd(W_IN, r); check("R8 loopback reads driven 1", bitof(r, 7), 32'h1);
        wr(W_OUTCLR, 32'h80);
        rd(W_IN, r); check("R8 loopback reads driven 0", bitof(r, 7), 32'h0);
    endtask

    task automatic t_conflict_r9();
        logic [31:0] r;
        wr(W_OUTSET, 32'h80);
        drive(7, 1'b1, 1'b1);
        @(negedge clk);
        check("R9 no conflict on agreeing drive", {31'd0, conflict_any}, 32'h0);
        drive(7, 1'b1, 1'b0);
        check("R11 conflict not yet registered", {31'd0, conflict_any}, 32'h0);
        @(negedge clk);
        check("R9 conflict one edge after opposing drive", {31'd0, conflict_any}, 32'h1);
        rd(W_IN, r); check("R8 output wins over external drive", bitof(r, 7), 32'h1);
        drive(7, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 conflict sticky after drive removed", {31'd0, conflict_any}, 32'h1);
        rd(W_CONFL, r); check("R9 status bit 7 set", r, 32'h80);
        wr(W_CONFL, 32'h1);
        rd(W_CONFL, r); check("R9 clearing other bit keeps bit 7", r, 32'h80);
        wr(W_CONFL, 32'h80);
        rd(W_CONFL, r); check("R9 write one clears bit 7", r, 32'h0);
        check("R9 conflict_any cleared", {31'd0, conflict_any}, 32'h0);
        wr(W_OUTCLR, 32'h80);
        wr(W_CFG + 7, 32'h2);
    endtask

    task automatic t_ignored_r10();
        logic [31:0] r;
        wr(W_CFG + 12, 32'hC);
        wr(W_IN, 32'h0);
        rd(W_IN, r); check("R10 input write ignored", bitof(r, 12), 32'h1);
        wr(W_IN, 32'hFFFF_FFFF);
        rd(W_OUT, r); check("R10 input write leaves out", r, 32'h0);
        rd(W_DIR, r); check("R10 input write leaves dir", r, 32'h0);
        rd(6'd8, r);  check("R10 unmapped word 8 reads 0", r, 32'h0);
        rd(6'd31, r); check("R10 unmapped word 31 reads 0", r, 32'h0);
        wr(W_CFG + 12, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_dir_r2_r3();
        t_out_r4();
        t_input_r5_r6();
        t_disc_r7();
        t_loop_r8();
        t_conflict_r9();
        t_ignored_r10();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule